// File: doc/BRIEF.md
# I2S Deserializer with AES3 Subframe Encoder

This block listens to up to four I2S serial data lines, each carrying a stereo pair, and uses the bit clock and word clock produced elsewhere in the audio path. Both clocks arrive as level inputs that are sampled in the system clock domain. For every completed stereo frame, each line's left and right samples are routed to an output channel pair chosen by a per-line route code. The block then issues one 32-bit AES3-style subframe word per enabled channel on a valid/ready stream. Each word carries a 3-bit channel number.

Each subframe word carries the following fields:

- A preamble code that marks the start of a 192-frame block, a left channel or a right channel.
- The sample.
- A validity bit taken from configuration.
- A user bit held at zero.
- One bit per frame of a 192-bit channel-status word.
- An even-parity bit.

The channel-status word is written into a programmed copy. A one-cycle latch command moves it into the active copy used for insertion. One-cycle event pulses report the end of each 192-frame block and any frame lost because the stream consumer was too slow.

Top module: `i2s_aes_encoder`

## Requirements
- R1: Every line is sampled on bit-clock rising edges, MSB first. A word starts at the rising edge where the word clock differs from its level at the previous rising edge, and only the first W bits of a slot are kept (W = 24 when `wide_mode` = 1, else 16). A slot with word clock low is the left (even) channel, and one with word clock high is the right (odd) channel. A frame is captured at the rising edge where the word clock falls from high to low.
- R2: The words of one frame leave in ascending channel order, and `m_chan` equals the channel number of the word on `m_data`.
- R3: Line n takes its route code from `route_in[3n+2:3n]`, loaded when `route_wr` is high. After reset, line n has code n+1. Code 0 disables the line. Codes 1, 2, 3 and 4 send its left/right samples to channels 0/1, 2/3, 4/5 and 6/7. Codes 5 to 7 disable the line. When several lines name the same pair, the lowest-numbered line wins. A pair that no line names is skipped.
- R4: `m_data[3:0]` is 4'b0001 for channel 0 of frame 0 of each block, 4'b0010 for every other even channel, and 4'b0011 for every odd channel.
- R5: `m_data[30]` of a word from frame k of a block is bit k of the active channel-status copy. A one-cycle `cs_latch` copies `cs_prog` into the active copy. A frame captured in the same cycle as the latch still uses the old active copy.
- R6: `m_data[28]` equals `valid_cfg` as sampled when the frame was captured, and `m_data[29]` is always 0.
- R7: In 24-bit mode the sample occupies `m_data[27:4]`. In 16-bit mode it occupies `m_data[27:12]` and `m_data[11:4]` are 0.
- R8: `m_data[31]` makes `m_data[31:4]` have an even number of ones.
- R9: A word stays on the stream, unchanged, until it is accepted. If any word of the previous frame is still unaccepted after the capture cycle, the newly captured frame is discarded and `ovf` is high for one cycle.
- R10: The frame counter advances on every captured frame, discarded ones included, and wraps after 192 frames. `blk_done` is high for one cycle after the capture of frame 191.
- R11: After a synchronous active-high reset:
  - `m_valid`, `ovf` and `blk_done` are 0.
  - The frame counter and the active channel-status copy are 0.
  - Routes hold their default codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Bit clock level |
| lrclk | input | 1 | Word clock level (low = left) |
| sdata | input | LINES | Serial data, one bit per line |
| wide_mode | input | 1 | 1 = 24-bit samples, 0 = 16-bit |
| valid_cfg | input | 1 | Validity bit inserted into words |
| route_wr | input | 1 | Load strobe for route codes |
| route_in | input | 3*LINES | Route codes, 3 bits per line |
| cs_latch | input | 1 | One-cycle command copying the programmed status |
| cs_prog | input | BLOCK | Programmed channel-status word |
| m_data | output | 32 | Subframe word |
| m_chan | output | 3 | Channel number of the word |
| m_valid | output | 1 | Word available |
| m_ready | input | 1 | Consumer accepts the word |
| blk_done | output | 1 | Pulse after the last frame of a block |
| ovf | output | 1 | Pulse when a frame is discarded |

## Verification
Two of this block's functions can fall in the same cycle: the channel-status latch command and the capture of a frame. The bench provokes this by raising `cs_latch` on exactly the clock in which the bit-clock rise closes a right slot. That capture is of frame 3, whose programmed bit is 1 while the active bit is still 0. The bench expects bit 30 of that frame's words to carry the old value and later frames to carry the new one.

Frame discards against a stalled consumer are also judged cycle by cycle. This includes the case where the last word of the old frame is accepted in the capture cycle itself.

// File: rtl/i2s_aes_encoder.sv
module i2s_aes_encoder #(
  parameter int LINES = 4,
  parameter int BLOCK = 192
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk,
  input  logic               lrclk,
  input  logic [LINES-1:0]   sdata,
  input  logic               wide_mode,
  input  logic               valid_cfg,
  input  logic               route_wr,
  input  logic [3*LINES-1:0] route_in,
  input  logic               cs_latch,
  input  logic [BLOCK-1:0]   cs_prog,
  output logic [31:0]        m_data,
  output logic [2:0]         m_chan,
  output logic               m_valid,
  input  logic               m_ready,
  output logic               blk_done,
  output logic               ovf
);
  localparam int PAIRS = 4;
  localparam int CHANS = 2 * PAIRS;
  localparam int CW    = $clog2(CHANS);
  localparam int FW    = $clog2(BLOCK);
  localparam int SW    = 24;

  function automatic logic [SW-1:0] place(input logic [SW-1:0] x, input logic w);
    return w ? x : {x[15:0], 8'h00};
  endfunction

  logic                      sclk_q, lr_q;
  logic [4:0]                cnt_q;
  logic [LINES-1:0][SW-1:0]  shreg_q, left_q;
  logic [LINES-1:0][2:0]     route_q;
  logic [BLOCK-1:0]          cs_act_q;
  logic [FW-1:0]             fidx_q;
  logic [CHANS-1:0][SW-1:0]  buf_q;
  logic [CHANS-1:0]          pend_q;
  logic                      first_q, cbit_q, vbit_q;

  wire       rise    = sclk & ~sclk_q;
  wire       edge_lr = rise & (lrclk ^ lr_q);
  wire       grab    = edge_lr & lr_q;
  wire [4:0] wlen    = wide_mode ? 5'd24 : 5'd16;
  wire       last_f  = (fidx_q == FW'(BLOCK-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      lr_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk;
      if (rise) begin
        lr_q <= lrclk;
        if (edge_lr)           cnt_q <= 5'd1;
        else if (cnt_q < wlen) cnt_q <= cnt_q + 5'd1;
      end
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        shreg_q[l] <= '0;
        left_q[l]  <= '0;
        route_q[l] <= 3'(l + 1);
      end else begin
        if (rise) begin
          if (edge_lr)           shreg_q[l] <= {{(SW-1){1'b0}}, sdata[l]};
          else if (cnt_q < wlen) shreg_q[l] <= {shreg_q[l][SW-2:0], sdata[l]};
          if (edge_lr && !lr_q)  left_q[l]  <= shreg_q[l];
        end
        if (route_wr) route_q[l] <= route_in[3*l +: 3];
      end
    end
  end

  logic [CHANS-1:0][SW-1:0] fr_data;
  logic [CHANS-1:0]         fr_en;
  always_comb begin
    fr_data = '0;
    fr_en   = '0;
    for (int p = 0; p < PAIRS; p++) begin
      for (int l = LINES - 1; l >= 0; l--) begin
        if (route_q[l] == 3'(p + 1)) begin
          fr_en[2*p]     = 1'b1;
          fr_en[2*p+1]   = 1'b1;
          fr_data[2*p]   = place(left_q[l], wide_mode);
          fr_data[2*p+1] = place(shreg_q[l], wide_mode);
        end
      end
    end
  end

  logic [CW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = CHANS - 1; i >= 0; i--)
      if (pend_q[i]) sel = CW'(i);
  end

  wire             acc        = m_valid & m_ready;
  wire [CHANS-1:0] left_after = pend_q & ~(CHANS'(acc) << sel);
  wire             busy       = |left_after;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      buf_q    <= '0;
      fidx_q   <= '0;
      first_q  <= 1'b0;
      cbit_q   <= 1'b0;
      vbit_q   <= 1'b0;
      blk_done <= 1'b0;
      ovf      <= 1'b0;
      cs_act_q <= '0;
    end else begin
      blk_done <= 1'b0;
      ovf      <= 1'b0;
      pend_q   <= left_after;
      if (cs_latch) cs_act_q <= cs_prog;
      if (grab) begin
        fidx_q   <= last_f ? '0 : fidx_q + FW'(1);
        blk_done <= last_f;
        if (busy) begin
          ovf <= 1'b1;
        end else begin
          pend_q  <= fr_en;
          buf_q   <= fr_data;
          first_q <= (fidx_q == '0);
          cbit_q  <= cs_act_q[fidx_q];
          vbit_q  <= valid_cfg;
        end
      end
    end
  end

  wire [3:0]  pre  = sel[0] ? 4'b0011 : (first_q && sel == '0) ? 4'b0001 : 4'b0010;
  wire [26:0] body = {cbit_q, 1'b0, vbit_q, buf_q[sel]};

  assign m_valid = |pend_q;
  assign m_chan  = sel;
  assign m_data  = {^body, body, pre};

  a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_chan));
  a_r9_ovf_busy: assert property (@(posedge clk) disable iff (rst)
    ovf |-> m_valid);
  a_r8_even_parity: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (^m_data[31:4]) == 1'b0);
  a_r6_user_zero: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !m_data[29]);
  a_r4_odd_preamble: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_chan[0] |-> m_data[3:0] == 4'b0011);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done);
endmodule

// File: tb/sim_i2s_aes_encoder.sv
module sim_i2s_aes_encoder;
  localparam int LINES = 4;
  localparam int BLOCK = 192;
  localparam int HP    = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, sclk = 1'b0, lrclk = 1'b0, wide_mode = 1'b1, valid_cfg = 1'b0;
  logic route_wr = 1'b0, cs_latch = 1'b0, m_ready = 1'b1;
  logic [LINES-1:0]   sdata = '0;
  logic [3*LINES-1:0] route_in = '0;
  logic [BLOCK-1:0]   cs_prog = '0;
  logic [31:0] m_data;
  logic [2:0]  m_chan;
  logic        m_valid, blk_done, ovf;

  i2s_aes_encoder #(.LINES(LINES), .BLOCK(BLOCK)) u0 (
    .clk(clk), .rst(rst), .sclk(sclk), .lrclk(lrclk), .sdata(sdata),
    .wide_mode(wide_mode), .valid_cfg(valid_cfg), .route_wr(route_wr),
    .route_in(route_in), .cs_latch(cs_latch), .cs_prog(cs_prog),
    .m_data(m_data), .m_chan(m_chan), .m_valid(m_valid), .m_ready(m_ready),
    .blk_done(blk_done), .ovf(ovf));

  int checks = 0, errs = 0, ovf_seen = 0, blk_seen = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [23:0] cur_l[LINES], cur_r[LINES], nxt_l[LINES], nxt_r[LINES], fin_l[LINES], fin_r[LINES];
  initial for (int l = 0; l < LINES; l++) begin
    cur_l[l] = '0; cur_r[l] = '0; fin_l[l] = '0; fin_r[l] = '0;
  end

  logic [31:0] qd[$];
  int          qc[$];
  logic        m_sclk = 1'b0, m_lr = 1'b0, e_ovf = 1'b0, e_blk = 1'b0;
  int          m_fidx = 0;
  logic [BLOCK-1:0] m_cs = '0;
  logic [2:0]  m_route[LINES];
  initial for (int l = 0; l < LINES; l++) m_route[l] = 3'(l + 1);

  task automatic model_capture();
    logic [23:0] s, aud;
    logic [31:0] w;
    int src;
    e_blk = (m_fidx == BLOCK - 1);
    if (qd.size() > 0) e_ovf = 1'b1;
    else begin
      for (int ch = 0; ch < 8; ch++) begin
        src = -1;
        for (int l = LINES - 1; l >= 0; l--) if (m_route[l] == 3'(ch / 2 + 1)) src = l;
        if (src >= 0) begin
          s   = (ch % 2 == 0) ? fin_l[src] : fin_r[src];
          aud = wide_mode ? s : {s[15:0], 8'h00};
          w[3:0]  = (ch == 0 && m_fidx == 0) ? 4'b0001 : (ch % 2 == 1) ? 4'b0011 : 4'b0010;
          w[27:4] = aud;
          w[28]   = valid_cfg;
          w[29]   = 1'b0;
          w[30]   = m_cs[m_fidx];
          w[31]   = ^w[30:4];
          qd.push_back(w);
          qc.push_back(ch);
        end
      end
    end
    m_fidx = (m_fidx + 1) % BLOCK;
  endtask

  always @(negedge clk) begin
    chk("R2 R9 valid", {31'b0, m_valid}, {31'b0, qd.size() > 0});
    if (qd.size() > 0 && m_valid === 1'b1) begin
      chk("R2 R3 channel", {29'b0, m_chan}, 32'(qc[0]));
      chk("R4 preamble", {28'b0, m_data[3:0]}, {28'b0, qd[0][3:0]});
      chk("R1 R3 R7 sample", {8'b0, m_data[27:4]}, {8'b0, qd[0][27:4]});
      chk("R6 validity/user", {30'b0, m_data[29:28]}, {30'b0, qd[0][29:28]});
      chk("R5 channel status", {31'b0, m_data[30]}, {31'b0, qd[0][30]});
      chk("R8 parity", {31'b0, m_data[31]}, {31'b0, qd[0][31]});
    end
    chk("R9 ovf", {31'b0, ovf}, {31'b0, e_ovf});
    chk("R10 blk_done", {31'b0, blk_done}, {31'b0, e_blk});
    if (ovf === 1'b1) ovf_seen++;
    if (blk_done === 1'b1) blk_seen++;
    e_ovf = 1'b0;
    e_blk = 1'b0;
    if (rst) begin
      qd.delete(); qc.delete();
      m_sclk = 1'b0; m_lr = 1'b0; m_fidx = 0; m_cs = '0;
      for (int l = 0; l < LINES; l++) m_route[l] = 3'(l + 1);
    end else begin
      if (m_ready && qd.size() > 0) begin
        void'(qd.pop_front()); void'(qc.pop_front());
      end
      if (sclk && !m_sclk) begin
        if (lrclk != m_lr && m_lr) model_capture();
        m_lr = lrclk;
      end
      m_sclk = sclk;
      if (cs_latch) m_cs = cs_prog;
      if (route_wr) for (int l = 0; l < LINES; l++) m_route[l] = route_in[3*l +: 3];
    end
  end

  int rdy_mode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #2;
    cyc++;
    case (rdy_mode)
      0: m_ready = 1'b1;
      1: m_ready = cyc[0] ^ cyc[3] ^ cyc[4];
      default: m_ready = 1'b0;
    endcase
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  function automatic logic [23:0] smp(input int f, input int l, input int s);
    logic [31:0] h;
    h = 32'(f * 40503 + l * 977 + s * 3119 + 7);
    h = h * 32'h9E3779B1;
    h = h ^ (h >> 15);
    return h[23:0];
  endfunction

  task automatic fill(input int f);
    for (int l = 0; l < LINES; l++) begin
      nxt_l[l] = smp(f, l, 0);
      nxt_r[l] = smp(f, l, 1);
    end
  endtask

  logic latch_req = 1'b0;
  task automatic send_frame(input int slot);
    int w;
    w = wide_mode ? 24 : 16;
    for (int l = 0; l < LINES; l++) begin
      fin_l[l] = cur_l[l]; fin_r[l] = cur_r[l];
      cur_l[l] = nxt_l[l]; cur_r[l] = nxt_r[l];
    end
    for (int h = 0; h < 2; h++) begin
      for (int b = 0; b < slot; b++) begin
        sclk  = 1'b0;
        lrclk = h[0];
        for (int l = 0; l < LINES; l++)
          sdata[l] = (b < w) ? ((h == 0) ? cur_l[l][w-1-b] : cur_r[l][w-1-b]) : b[0];
        repeat (HP) step();
        sclk = 1'b1;
        if (h == 0 && b == 0 && latch_req) begin
          cs_latch = 1'b1; step(); cs_latch = 1'b0; repeat (HP - 1) step();
          latch_req = 1'b0;
        end else repeat (HP) step();
      end
    end
  endtask

  task automatic set_route(input logic [2:0] c0, input logic [2:0] c1,
                           input logic [2:0] c2, input logic [2:0] c3);
    step();
    route_in = {c3, c2, c1, c0};
    route_wr = 1'b1;
    step();
    route_wr = 1'b0;
  endtask

  task automatic do_reset();
    sclk = 1'b0; lrclk = 1'b0; rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R11 reset valid", {31'b0, m_valid}, 32'd0);
    chk("R11 reset ovf", {31'b0, ovf}, 32'd0);
    chk("R11 reset blk_done", {31'b0, blk_done}, 32'd0);
  endtask

  initial begin
    int f;
    for (int k = 0; k < BLOCK; k++) cs_prog[k] = (k % 3 == 0);
    do_reset();
    f = 0;
    for (int n = 0; n < 200; n++) begin
      if (n == 4) latch_req = 1'b1;
      if (n == 10) set_route(3'd4, 3'd0, 3'd4, 3'd6);
      if (n == 14) set_route(3'd1, 3'd2, 3'd3, 3'd1);
      if (n == 18) set_route(3'd2, 3'd1, 3'd4, 3'd3);
      if (n == 20) valid_cfg = 1'b1;
      if (n == 24) rdy_mode = 1;
      if (n == 30) rdy_mode = 2;
      if (n == 33) rdy_mode = 0;
      if (n == 40) begin
        for (int k = 0; k < BLOCK; k++) cs_prog[k] = (k % 5 == 0);
        step(); cs_latch = 1'b1; step(); cs_latch = 1'b0;
      end
      if (n == 60) rdy_mode = 1;
      if (n == 120) valid_cfg = 1'b0;
      fill(f++);
      send_frame(24);
    end
    wide_mode = 1'b0;
    do_reset();
    for (int n = 0; n < 14; n++) begin
      if (n == 6) rdy_mode = 2;
      if (n == 8) rdy_mode = 1;
      fill(f++);
      send_frame(32);
    end
    repeat (20) step();
    chk("R9 overflow provoked", 32'(ovf_seen > 0), 32'd1);
    chk("R10 one block completed", 32'(blk_seen), 32'd1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule